// File: doc/BRIEF.md
# Configuration Access Router

The block sits between a configuration-space requester and a set of downstream ports. Each request carries a bus number, a device/function number, a 12-bit register offset, an access size and write data. The router works out which port owns the request and how to reach it. It then either answers the request itself with a status, or performs one sized access at that port.

Bus 0 holds the per-port local bridges. A request on bus 0 goes to the local bridge register strobe of the port whose device/function matches. A request on any other bus goes to the port whose secondary-to-subordinate bus range covers it. For those requests the router first writes a packed 32-bit configuration address word to that port's hardware access interface. In the next cycle it issues the sized data access. Link state and hidden slots can make a request fail as not found. The result comes back on a one-cycle response strobe.

Top module: `cfg_access_router`

## Requirements
- R1: On the hardware path, the address word has the following layout. Bit 31 is 1. Bits 30:28 are 0. Bits 23:16 hold the bus number. Bits 15:11 hold the device, which is devfn[7:3]. Bits 10:8 hold the function, which is devfn[2:0]. Bits 7:2 hold offset[7:2]. Bits 1:0 are 0.
- R2: Offset bits 11:8 appear in bits 27:24 of the address word.
- R3: A bus 0 request selects the lowest-index port whose device/function equals the request's. It raises `br_valid_o` for that port and makes no hardware access.
- R4: A request on a nonzero bus selects the lowest-index port with secondary <= bus <= subordinate. Overlapping ranges therefore resolve to the smaller index.
- R5: A request fails with status NOT_FOUND (1), response data 0xFFFFFFFF and no downstream access in either of two cases: no port matches, or the selected port's link-up input is low on a nonzero bus. A write in that case is dropped.
- R6: When the request bus equals the selected port's secondary bus and the device number is not 0, the request gets NOT_FOUND. Buses above the secondary bus, up to the subordinate bus, expose all devices.
- R7: The access size sets the byte lanes. Size 1 uses offset[1:0] as the byte lane. Size 2 uses offset[1] to pick halfword lane 0 or 2. Size 4 uses lane 0. Byte enables, write data and read data are all shifted to that lane, and read data is zero-extended.
- R8: A write whose size is not 1, 2 or 4 completes with status BAD_REG (2), response data 0 and no downstream access. A read of such a size behaves as a 4-byte read. Successful writes return status OK (0) with data 0.
- R9: A request is accepted at clock edge E0. On the hardware path, `hw_addr_valid_o` is high for the cycle after E0, `hw_data_valid_o` is high for the cycle after that, and `rsp_valid_o` pulses in the third cycle. On the bridge and error paths, `br_valid_o` (bridge only) is high in the first cycle and `rsp_valid_o` pulses in the second cycle.
- R10: `req_ready_o` is high only when the block is idle. Requests presented while it is low are ignored, and the request in flight is unaffected by input changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request present |
| req_ready_o | output | 1 | Block idle, request accepted when valid |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_bus_i | input | 8 | Bus number |
| req_devfn_i | input | 8 | Device [7:3], function [2:0] |
| req_off_i | input | 12 | Register byte offset |
| req_size_i | input | 3 | Access size in bytes |
| req_wdata_i | input | 32 | Write data, right-aligned |
| port_devfn_i | input | 8*NUM_PORTS | Per-port device/function on bus 0 |
| port_sec_i | input | 8*NUM_PORTS | Per-port secondary bus |
| port_sub_i | input | 8*NUM_PORTS | Per-port subordinate bus |
| port_link_up_i | input | NUM_PORTS | Per-port link up |
| br_valid_o | output | 1 | Local bridge register access strobe |
| br_reg_o | output | 10 | Bridge dword index, offset[11:2] |
| br_rdata_i | input | 32 | Bridge dword read data, same cycle |
| hw_addr_valid_o | output | 1 | Address word write strobe |
| hw_addr_o | output | 32 | Packed configuration address word |
| hw_data_valid_o | output | 1 | Sized data access strobe |
| hw_rdata_i | input | 32 | Hardware dword read data, same cycle |
| acc_port_o | output | $clog2(NUM_PORTS) | Target port of the current access |
| acc_write_o | output | 1 | Current access is a write |
| acc_be_o | output | 4 | Byte enables of the current access |
| acc_wdata_o | output | 32 | Lane-aligned write data |
| rsp_valid_o | output | 1 | Response pulse |
| rsp_status_o | output | 2 | 0 OK, 1 NOT_FOUND, 2 BAD_REG |
| rsp_rdata_o | output | 32 | Read data |

## Verification
The bench builds the block with the default of four ports and gives them these bus ranges:

| Port | Secondary | Subordinate |
|---|---|---|
| 0 | 1 | 3 |
| 1 | 4 | 4 |
| 2 | 2 | 6 |
| 3 | 10 | 12 |

Port 0 and port 2 overlap on buses 2 and 3, so those requests show the lowest-index rule. Buses 4 through 6 separate the secondary-bus hiding rule from the deeper-bus case. Port 3 starts with its link down and is brought up later. This exercises both outcomes of the link rule on the same range. Four ports also leave the bus 0 device/function lookup with a device/function value that matches no port.

// File: rtl/cfg_route_pkg.sv
package cfg_route_pkg;
  typedef enum logic [1:0] {CS_OK = 2'd0, CS_NOT_FOUND = 2'd1, CS_BAD_REG = 2'd2} cfg_status_e;
  typedef enum logic [1:0] {RT_NONE, RT_BRIDGE, RT_HW, RT_BAD} route_e;
  typedef enum logic [1:0] {ST_IDLE, ST_DECIDE, ST_DATA} state_e;
  typedef struct packed {
    logic        write;
    logic [7:0]  bus;
    logic [7:0]  devfn;
    logic [11:0] off;
    logic [2:0]  size;
    logic [31:0] wdata;
  } cfg_req_t;
endpackage

// File: rtl/cfg_port_match.sv
module cfg_port_match #(
  parameter int NUM_PORTS = 4,
  parameter int PORT_W    = 2
) (
  input  logic [7:0]             bus_i,
  input  logic [7:0]             devfn_i,
  input  logic [NUM_PORTS*8-1:0] port_devfn_i,
  input  logic [NUM_PORTS*8-1:0] port_sec_i,
  input  logic [NUM_PORTS*8-1:0] port_sub_i,
  output logic                   hit_o,
  output logic [PORT_W-1:0]      idx_o
);
  logic [NUM_PORTS-1:0] devfn_m, rng_m, cand;

  for (genvar i = 0; i < NUM_PORTS; i++) begin : g_port
    assign devfn_m[i] = (port_devfn_i[i*8 +: 8] == devfn_i);
    assign rng_m[i]   = (bus_i >= port_sec_i[i*8 +: 8]) && (bus_i <= port_sub_i[i*8 +: 8]);
  end

  assign cand = (bus_i == 8'd0) ? devfn_m : rng_m;

  // lowest index wins
  always_comb begin
    hit_o = 1'b0;
    idx_o = '0;
    for (int i = NUM_PORTS - 1; i >= 0; i--) begin
      if (cand[i]) begin
        hit_o = 1'b1;
        idx_o = PORT_W'(i);
      end
    end
  end
endmodule

// File: rtl/cfg_addr_pack.sv
module cfg_addr_pack (
  input  logic [7:0]  bus_i,
  input  logic [7:0]  devfn_i,
  input  logic [11:2] off_i,
  output logic [31:0] addr_o
);
  // enable | ext reg | bus | dev,fn | dword
  assign addr_o = {1'b1, 3'b000, off_i[11:8], bus_i, devfn_i, off_i[7:2], 2'b00};
endmodule

// File: rtl/cfg_lane.sv
module cfg_lane (
  input  logic [2:0]  size_i,
  input  logic [1:0]  off_i,
  input  logic [31:0] wdata_i,
  input  logic [31:0] rdata_i,
  output logic [3:0]  be_o,
  output logic [31:0] wdata_o,
  output logic [31:0] rdata_o
);
  logic [1:0]  shift;
  logic [31:0] mask;
  logic [3:0]  be_base;

  always_comb begin
    case (size_i)
      3'd1:    begin shift = off_i;            mask = 32'h0000_00ff; be_base = 4'b0001; end
      3'd2:    begin shift = {off_i[1], 1'b0}; mask = 32'h0000_ffff; be_base = 4'b0011; end
      default: begin shift = 2'd0;             mask = 32'hffff_ffff; be_base = 4'b1111; end
    endcase
  end

  assign be_o    = be_base << shift;
  assign wdata_o = (wdata_i & mask) << {shift, 3'b000};
  assign rdata_o = (rdata_i >> {shift, 3'b000}) & mask;
endmodule

// File: rtl/cfg_access_router.sv
module cfg_access_router
  import cfg_route_pkg::*;
#(
  parameter  int NUM_PORTS = 4,
  localparam int PORT_W    = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   req_valid_i,
  output logic                   req_ready_o,
  input  logic                   req_write_i,
  input  logic [7:0]             req_bus_i,
  input  logic [7:0]             req_devfn_i,
  input  logic [11:0]            req_off_i,
  input  logic [2:0]             req_size_i,
  input  logic [31:0]            req_wdata_i,
  input  logic [NUM_PORTS*8-1:0] port_devfn_i,
  input  logic [NUM_PORTS*8-1:0] port_sec_i,
  input  logic [NUM_PORTS*8-1:0] port_sub_i,
  input  logic [NUM_PORTS-1:0]   port_link_up_i,
  output logic                   br_valid_o,
  output logic [9:0]             br_reg_o,
  input  logic [31:0]            br_rdata_i,
  output logic                   hw_addr_valid_o,
  output logic [31:0]            hw_addr_o,
  output logic                   hw_data_valid_o,
  input  logic [31:0]            hw_rdata_i,
  output logic [PORT_W-1:0]      acc_port_o,
  output logic                   acc_write_o,
  output logic [3:0]             acc_be_o,
  output logic [31:0]            acc_wdata_o,
  output logic                   rsp_valid_o,
  output logic [1:0]             rsp_status_o,
  output logic [31:0]            rsp_rdata_o
);
  state_e            st_q;
  cfg_req_t          req_q;
  logic [PORT_W-1:0] port_q;
  logic              rsp_valid_q;
  cfg_status_e       rsp_status_q;
  logic [31:0]       rsp_rdata_q;

  logic              sel_hit;
  logic [PORT_W-1:0] sel_idx;
  logic [7:0]        sec_a [NUM_PORTS];
  logic              size_ok;
  route_e            route;
  logic [31:0]       rd_src, rd_fmt;

  for (genvar i = 0; i < NUM_PORTS; i++) begin : g_sec
    assign sec_a[i] = port_sec_i[i*8 +: 8];
  end

  cfg_port_match #(.NUM_PORTS(NUM_PORTS), .PORT_W(PORT_W)) i_match (
    .bus_i        (req_q.bus),
    .devfn_i      (req_q.devfn),
    .port_devfn_i (port_devfn_i),
    .port_sec_i   (port_sec_i),
    .port_sub_i   (port_sub_i),
    .hit_o        (sel_hit),
    .idx_o        (sel_idx)
  );

  cfg_addr_pack i_pack (
    .bus_i   (req_q.bus),
    .devfn_i (req_q.devfn),
    .off_i   (req_q.off[11:2]),
    .addr_o  (hw_addr_o)
  );

  assign rd_src = (st_q == ST_DATA) ? hw_rdata_i : br_rdata_i;

  cfg_lane i_lane (
    .size_i  (req_q.size),
    .off_i   (req_q.off[1:0]),
    .wdata_i (req_q.wdata),
    .rdata_i (rd_src),
    .be_o    (acc_be_o),
    .wdata_o (acc_wdata_o),
    .rdata_o (rd_fmt)
  );

  assign size_ok = (req_q.size == 3'd1) || (req_q.size == 3'd2) || (req_q.size == 3'd4);

  always_comb begin
    if (!sel_hit)                                   route = RT_NONE;
    else if (req_q.bus == 8'd0)                     route = (req_q.write && !size_ok) ? RT_BAD : RT_BRIDGE;
    else if (!port_link_up_i[sel_idx])              route = RT_NONE;
    else if (req_q.bus == sec_a[sel_idx] && req_q.devfn[7:3] != 5'd0) route = RT_NONE;
    else if (req_q.write && !size_ok)               route = RT_BAD;
    else                                            route = RT_HW;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q         <= ST_IDLE;
      req_q        <= '0;
      port_q       <= '0;
      rsp_valid_q  <= 1'b0;
      rsp_status_q <= CS_OK;
      rsp_rdata_q  <= '0;
    end else begin
      rsp_valid_q <= 1'b0;
      case (st_q)
        ST_IDLE: if (req_valid_i) begin
          req_q <= '{write: req_write_i, bus: req_bus_i, devfn: req_devfn_i,
                     off: req_off_i, size: req_size_i, wdata: req_wdata_i};
          st_q  <= ST_DECIDE;
        end
        ST_DECIDE: begin
          if (route == RT_HW) begin
            port_q <= sel_idx;
            st_q   <= ST_DATA;
          end else begin
            rsp_valid_q <= 1'b1;
            st_q        <= ST_IDLE;
            case (route)
              RT_NONE: begin rsp_status_q <= CS_NOT_FOUND; rsp_rdata_q <= 32'hffff_ffff; end
              RT_BAD:  begin rsp_status_q <= CS_BAD_REG;   rsp_rdata_q <= '0; end
              default: begin rsp_status_q <= CS_OK; rsp_rdata_q <= req_q.write ? '0 : rd_fmt; end
            endcase
          end
        end
        ST_DATA: begin
          rsp_valid_q  <= 1'b1;
          rsp_status_q <= CS_OK;
          rsp_rdata_q  <= req_q.write ? '0 : rd_fmt;
          st_q         <= ST_IDLE;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign req_ready_o     = (st_q == ST_IDLE);
  assign br_valid_o      = (st_q == ST_DECIDE) && (route == RT_BRIDGE);
  assign br_reg_o        = req_q.off[11:2];
  assign hw_addr_valid_o = (st_q == ST_DECIDE) && (route == RT_HW);
  assign hw_data_valid_o = (st_q == ST_DATA);
  assign acc_port_o      = (st_q == ST_DATA) ? port_q : sel_idx;
  assign acc_write_o     = req_q.write;
  assign rsp_valid_o     = rsp_valid_q;
  assign rsp_status_o    = rsp_status_q;
  assign rsp_rdata_o     = rsp_rdata_q;
endmodule

// File: rtl/cfg_router_checker.sv
module cfg_router_checker #(
  parameter int NUM_PORTS = 4,
  parameter int PORT_W    = 2
) (
  input logic                   clk_i,
  input logic                   rst_ni,
  input logic                   req_ready_i,
  input logic                   br_valid_i,
  input logic                   hw_addr_valid_i,
  input logic                   hw_data_valid_i,
  input logic [7:0]             addr_bus_i,
  input logic [4:0]             addr_dev_i,
  input logic [PORT_W-1:0]      acc_port_i,
  input logic [NUM_PORTS*8-1:0] port_sec_i,
  input logic [NUM_PORTS-1:0]   port_link_up_i,
  input logic                   rsp_valid_i,
  input logic [1:0]             rsp_status_i,
  input logic [31:0]            rsp_rdata_i
);
  logic [7:0] sec_a [NUM_PORTS];
  for (genvar i = 0; i < NUM_PORTS; i++) begin : g_sec
    assign sec_a[i] = port_sec_i[i*8 +: 8];
  end

  a_r9_addr_then_data: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hw_addr_valid_i |=> hw_data_valid_i);
  a_r9_data_after_addr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hw_data_valid_i |-> $past(hw_addr_valid_i));
  a_r9_rsp_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_i |=> !rsp_valid_i);
  a_r1_hw_bus_nonzero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hw_addr_valid_i |-> addr_bus_i != 8'd0);
  a_r5_link_up: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hw_addr_valid_i |-> port_link_up_i[acc_port_i]);
  a_r5_nf_data: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_valid_i && rsp_status_i == 2'd1) |-> rsp_rdata_i == 32'hffff_ffff);
  a_r3_exclusive: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(br_valid_i && hw_addr_valid_i));
  a_r6_hidden: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hw_addr_valid_i && addr_bus_i == sec_a[acc_port_i]) |-> addr_dev_i == 5'd0);
  a_r10_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (br_valid_i || hw_addr_valid_i || hw_data_valid_i) |-> !req_ready_i);
endmodule

bind cfg_access_router cfg_router_checker #(.NUM_PORTS(NUM_PORTS), .PORT_W(PORT_W)) i_checker (
  .clk_i           (clk_i),
  .rst_ni          (rst_ni),
  .req_ready_i     (req_ready_o),
  .br_valid_i      (br_valid_o),
  .hw_addr_valid_i (hw_addr_valid_o),
  .hw_data_valid_i (hw_data_valid_o),
  .addr_bus_i      (hw_addr_o[23:16]),
  .addr_dev_i      (hw_addr_o[15:11]),
  .acc_port_i      (acc_port_o),
  .port_sec_i      (port_sec_i),
  .port_link_up_i  (port_link_up_i),
  .rsp_valid_i     (rsp_valid_o),
  .rsp_status_i    (rsp_status_o),
  .rsp_rdata_i     (rsp_rdata_o)
);

// File: tb/test_cfg_access_router.sv
module test_cfg_access_router;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 20000;
  localparam int K_NF = 0, K_BR = 1, K_HW = 2, K_BAD = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic        req_valid = 1'b0, req_write = 1'b0;
  logic [7:0]  req_bus = '0, req_devfn = '0;
  logic [11:0] req_off = '0;
  logic [2:0]  req_size = '0;
  logic [31:0] req_wdata = '0;
  logic [3:0]  link_v = 4'b0111;
  logic        req_ready, br_valid, hw_addr_valid, hw_data_valid, acc_write, rsp_valid;
  logic [9:0]  br_reg;
  logic [31:0] br_rdata, hw_addr, hw_rdata, acc_wdata, rsp_rdata;
  logic [1:0]  acc_port, rsp_status;
  logic [3:0]  acc_be;

  int m_devfn [4] = '{8'h00, 8'h08, 8'h10, 8'h18};
  int m_sec   [4] = '{1, 4, 2, 10};
  int m_sub   [4] = '{3, 4, 6, 12};
  int n_chk = 0, n_fail = 0;

  assign hw_rdata = hw_addr ^ 32'h5a5a_c3c3;
  assign br_rdata = 32'h1357_9bd0 | {30'd0, acc_port};

  cfg_access_router i_cfg_access_router (
    .clk_i(clk), .rst_ni(rst_n),
    .req_valid_i(req_valid), .req_ready_o(req_ready), .req_write_i(req_write),
    .req_bus_i(req_bus), .req_devfn_i(req_devfn), .req_off_i(req_off),
    .req_size_i(req_size), .req_wdata_i(req_wdata),
    .port_devfn_i({8'h18, 8'h10, 8'h08, 8'h00}),
    .port_sec_i({8'd10, 8'd2, 8'd4, 8'd1}),
    .port_sub_i({8'd12, 8'd6, 8'd4, 8'd3}),
    .port_link_up_i(link_v),
    .br_valid_o(br_valid), .br_reg_o(br_reg), .br_rdata_i(br_rdata),
    .hw_addr_valid_o(hw_addr_valid), .hw_addr_o(hw_addr),
    .hw_data_valid_o(hw_data_valid), .hw_rdata_i(hw_rdata),
    .acc_port_o(acc_port), .acc_write_o(acc_write), .acc_be_o(acc_be), .acc_wdata_o(acc_wdata),
    .rsp_valid_o(rsp_valid), .rsp_status_o(rsp_status), .rsp_rdata_o(rsp_rdata)
  );

  task automatic chk(string tg, string what, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%h expected=%h", tg, what, act, exp);
    end
  endtask

  function automatic void model(int bus, int devfn, int sz, bit wr, output int kind, output int idx);
    bit ok = (sz == 1) || (sz == 2) || (sz == 4);
    idx = -1;
    for (int i = 0; i < 4; i++)
      if (idx < 0 && ((bus == 0) ? (m_devfn[i] == devfn) : (bus >= m_sec[i] && bus <= m_sub[i])))
        idx = i;
    if (idx < 0) kind = K_NF;
    else if (bus == 0) kind = (wr && !ok) ? K_BAD : K_BR;
    else if (!link_v[idx]) kind = K_NF;
    else if (bus == m_sec[idx] && devfn / 8 != 0) kind = K_NF;
    else if (wr && !ok) kind = K_BAD;
    else kind = K_HW;
  endfunction

  task automatic do_req(string tg, bit wr, int bus, int devfn, int off, int sz,
                        logic [31:0] wd, bit junk);
    int kind, idx, shift, nb;
    logic [31:0] ea, mask, ebe, ewd, erd;
    model(bus, devfn, sz, wr, kind, idx);
    shift = (sz == 1) ? off % 4 : (sz == 2) ? (off % 4) & 2 : 0;
    nb    = (sz == 1) ? 1 : (sz == 2) ? 2 : 4;
    mask  = (nb == 4) ? 32'hffff_ffff : (32'd1 << (8 * nb)) - 1;
    ebe   = ((32'd1 << nb) - 1) << shift;
    ewd   = (wd & mask) << (8 * shift);
    ea    = 32'h8000_0000 | ((off / 256) << 24) | (bus << 16) | ((devfn / 8) << 11)
          | ((devfn % 8) << 8) | (((off % 256) / 4) << 2);
    if (kind == K_NF) erd = 32'hffff_ffff;
    else if (kind == K_BAD || wr) erd = 0;
    else if (kind == K_BR) erd = ((32'h1357_9bd0 | idx) >> (8 * shift)) & mask;
    else erd = ((ea ^ 32'h5a5a_c3c3) >> (8 * shift)) & mask;

    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_bus = 8'(bus); req_devfn = 8'(devfn);
    req_off = 12'(off); req_size = 3'(sz); req_wdata = wd;
    chk(tg, "ready_idle R10", {31'd0, req_ready}, 1);
    for (int c = 1; c <= 4; c++) begin
      @(negedge clk);
      if (c == 1 && junk) begin
        req_bus = 8'h00; req_devfn = 8'h08; req_write = ~wr; req_off = 12'hffc; req_size = 3'd1;
      end else req_valid = 1'b0;
      chk(tg, "br_valid R3", {31'd0, br_valid}, (kind == K_BR && c == 1) ? 1 : 0);
      chk(tg, "hw_addr_valid R9", {31'd0, hw_addr_valid}, (kind == K_HW && c == 1) ? 1 : 0);
      chk(tg, "hw_data_valid R9", {31'd0, hw_data_valid}, (kind == K_HW && c == 2) ? 1 : 0);
      chk(tg, "rsp_valid R9", {31'd0, rsp_valid},
          ((kind != K_HW && c == 2) || (kind == K_HW && c == 3)) ? 1 : 0);
      chk(tg, "ready R10", {31'd0, req_ready}, (c == 1 || (kind == K_HW && c == 2)) ? 0 : 1);
      if ((kind == K_BR || kind == K_HW) && c == 1) begin
        chk(tg, "port R4", {30'd0, acc_port}, idx);
        chk(tg, "be R7", {28'd0, acc_be}, ebe);
        chk(tg, "wdata R7", acc_wdata, ewd);
        chk(tg, "write", {31'd0, acc_write}, {31'd0, wr});
      end
      if (kind == K_BR && c == 1) chk(tg, "br_reg R3", {22'd0, br_reg}, off / 4);
      if (kind == K_HW && c == 1) chk(tg, "addr R1 R2", hw_addr, ea);
      if (kind == K_HW && c == 2) begin
        chk(tg, "data port R4", {30'd0, acc_port}, idx);
        chk(tg, "data be R7", {28'd0, acc_be}, ebe);
      end
      if (rsp_valid) begin
        chk(tg, "status", {30'd0, rsp_status},
            (kind == K_NF) ? 1 : (kind == K_BAD) ? 2 : 0);
        chk(tg, "rdata", rsp_rdata, erd);
      end
    end
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R10", "reset ready", {31'd0, req_ready}, 1);
    chk("R9", "reset rsp_valid", {31'd0, rsp_valid}, 0);
    chk("R9", "reset hw_addr_valid", {31'd0, hw_addr_valid}, 0);
    rst_n = 1'b1;
    do_req("R3", 0, 0, 8'h08, 12'h010, 4, 0, 0);
    do_req("R7", 1, 0, 8'h10, 12'h01e, 1, 32'hffff_ffab, 0);
    do_req("R5", 0, 0, 8'h20, 12'h000, 4, 0, 0);
    do_req("R2", 0, 1, 8'h00, 12'h104, 4, 0, 0);
    do_req("R4", 0, 3, 8'h2a, 12'h003, 1, 0, 0);
    do_req("R6", 0, 5, 8'h09, 12'h046, 2, 0, 0);
    do_req("R6", 0, 4, 8'h08, 12'h000, 4, 0, 0);
    do_req("R5", 0, 11, 8'h00, 12'h000, 4, 0, 0);
    do_req("R5", 1, 20, 8'h00, 12'h000, 4, 32'h1, 0);
    do_req("R8", 1, 1, 8'h00, 12'h008, 3, 32'h55, 0);
    do_req("R8", 1, 0, 8'h00, 12'h008, 0, 32'h55, 0);
    do_req("R8", 0, 4, 8'h00, 12'h00e, 3, 0, 0);
    do_req("R10", 1, 2, 8'h00, 12'h00a, 2, 32'hdead_1234, 1);
    do_req("R10", 1, 0, 8'h18, 12'h3c2, 2, 32'h0000_beef, 1);
    do_req("R1", 0, 12, 8'hff, 12'hffd, 1, 0, 0);
    link_v = 4'b1111;
    do_req("R5", 0, 10, 8'h00, 12'h800, 2, 0, 0);
    do_req("R6", 0, 10, 8'h10, 12'h000, 4, 0, 0);
    finish_run();
  end
endmodule